// File: doc/BRIEF.md
# Restricted-Range Rounded Quotient Unit

This unit forms the rounded quotient q = round(dot / n), where `dot` is a signed inner product and `n` is an unsigned squared vector norm. It never divides. The unit doubles the magnitude of `dot` and compares it, all at once, with the odd multiples 1, 3, 5, 7 and 9 of `n`. It builds those multiples from shifted copies of `n` that it adds together. A small priority table turns the pattern of comparison results into a magnitude between 0 and 4. The sign of `dot` is then put back on that magnitude.

The unit is meant for a vector-reduction datapath. The quotient it returns scales the subtraction of one vector from another. When the true quotient is larger than the supported range, the unit raises an overflow flag and forces the quotient to zero, so the vector being reduced is left unchanged. A separate flag says whether a reduction takes place, which happens when the quotient is nonzero.

There is one register stage. Operands presented before a rising clock edge appear as registered results just after that edge.

Top module: `rquot_unit`

## Requirements
- R1: While `rst_n` is low, the outputs are zero: `q_o` = 0, `reduce_o` = 0 and `ovf_o` = 0. Reset is asynchronous, so the outputs clear as soon as `rst_n` falls, without waiting for a clock edge.
- R2: The unit samples `dot_i` and `nrm_i` at a rising edge of `clk` and presents the result for them after that same edge. The result holds until the next edge.
- R3: When 2·|dot| < n, the result is `q_o` = 0 and `reduce_o` = 0.
- R4: For k from 1 to 4, when (2k−1)·n ≤ 2·|dot| < (2k+1)·n, the magnitude of `q_o` is k. An exact tie on a boundary takes the larger magnitude.
- R5: `q_o` is a 4-bit two's complement value. It is negative exactly when `dot_i` is negative and the magnitude is nonzero.
- R6: When 2·|dot| ≥ 9·n, `ovf_o` = 1, `q_o` = 0 and `reduce_o` = 0. Otherwise `ovf_o` = 0.
- R7: `reduce_o` is 1 exactly when `q_o` is nonzero.
- R8: When n = 0, `ovf_o` = 1 for every value of `dot_i`, including zero.
- R9: No intermediate value wraps for any operand values. This covers the most negative `dot_i` together with the largest `nrm_i`, and dot values just either side of 9·n when n is large.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_i | input | DOT_W | Signed inner product (two's complement) |
| nrm_i | input | NRM_W | Unsigned squared norm n |
| q_o | output | 4 | Signed rounded quotient, −4 to 4 |
| reduce_o | output | 1 | High when the quotient is nonzero |
| ovf_o | output | 1 | High when the quotient is outside ±4 |

## Verification
The bench drives every rounding boundary from both sides, for both signs of `dot` and for even and odd norms. A design that treats a tie as strict, or that compares against even multiples of n, would return a magnitude one too small at those points. The most negative `dot` combined with the largest norm, and values around 9·n for a large n, expose any comparison that is one bit too narrow: such a design would report a small quotient where overflow is due, or overflow where a quotient of 1 is due. A zero norm, a negative `dot` that rounds to zero, and a result that overflows catch, respectively, a design that divides by zero, one that produces a negative zero or a sign with no magnitude, and one that passes a nonzero quotient through while overflowing.

// File: rtl/rqu_pkg.sv
`timescale 1ns/1ps
package rqu_pkg;
    // Largest quotient magnitude the unit resolves
    localparam int QMAX  = 4;
    // One comparison per odd multiple 1, 3, .., 2*QMAX+1
    localparam int N_THR = QMAX + 1;
    localparam int MAG_W = $clog2(QMAX + 1);
    localparam int Q_W   = MAG_W + 1;
    // Bits needed to hold the largest odd multiplier
    localparam int MUL_B = $clog2(2 * QMAX + 2);

    typedef struct packed {
        logic signed [Q_W-1:0] q;
        logic                  red;
        logic                  ovf;
    } rqu_res_t;
endpackage

// File: rtl/rqu_abs.sv
`timescale 1ns/1ps
// Splits the signed operand into its sign and twice its magnitude.
module rqu_abs #(
    parameter int DOT_W = 32
) (
    input  logic signed [DOT_W-1:0] dot_i,
    output logic [DOT_W:0]          twice_mag_o,
    output logic                    neg_o
);
    logic [DOT_W-1:0] mag;

    always_comb begin
        neg_o = dot_i[DOT_W-1];
        // The most negative value maps onto 2^(DOT_W-1), which still fits unsigned
        mag = neg_o ? (~dot_i + 1'b1) : dot_i;
        twice_mag_o = {mag, 1'b0};
    end
endmodule

// File: rtl/rqu_thresh.sv
`timescale 1ns/1ps
// Parallel comparisons of 2|dot| against odd multiples of the norm.
// Each multiple is formed from shifted copies of the norm added together.
module rqu_thresh #(
    parameter int NRM_W = 32,
    parameter int CMP_W = 36,
    parameter int N_THR = 5,
    parameter int MUL_B = 4
) (
    input  logic [NRM_W-1:0] nrm_i,
    input  logic [CMP_W-1:0] lhs_i,
    output logic [N_THR-1:0] ge_o
);
    for (genvar k = 0; k < N_THR; k++) begin : g_thr
        localparam int ODD = 2 * k + 1;
        logic [CMP_W-1:0] mult;

        always_comb begin
            mult = '0;
            for (int b = 0; b < MUL_B; b++) begin
                if (((ODD >> b) & 1) != 0) begin
                    mult = mult + (CMP_W'(nrm_i) << b);
                end
            end
            ge_o[k] = (lhs_i >= mult);
        end
    end
endmodule

// File: rtl/rqu_select.sv
`timescale 1ns/1ps
// Maps the thermometer of comparison results onto a magnitude and an overflow flag.
module rqu_select #(
    parameter int N_THR = 5,
    parameter int MAG_W = 3
) (
    input  logic [N_THR-1:0] ge_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             ovf_o
);
    always_comb begin
        ovf_o = ge_i[N_THR-1];
        mag_o = '0;
        // The highest threshold passed decides the magnitude
        for (int k = 0; k < N_THR - 1; k++) begin
            if (ge_i[k]) begin
                mag_o = MAG_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/rquot_unit.sv
`timescale 1ns/1ps
module rquot_unit
    import rqu_pkg::*;
#(
    parameter int DOT_W = 32,
    parameter int NRM_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [DOT_W-1:0] dot_i,
    input  logic [NRM_W-1:0]        nrm_i,
    output logic signed [Q_W-1:0]   q_o,
    output logic                    reduce_o,
    output logic                    ovf_o
);
    // Wide enough for 2|dot| and for (2*QMAX+1)*n without wrap
    localparam int LHS_W = DOT_W + 1;
    localparam int RHS_W = NRM_W + MUL_B;
    localparam int CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;

    logic [DOT_W:0]     twice_mag_w;
    logic               neg_w;
    logic [N_THR-1:0]   ge_w;
    logic [MAG_W-1:0]   mag_w;
    logic               ovf_w;
    logic [Q_W-1:0]     magq_w;
    rqu_res_t           res_d;
    rqu_res_t           res_q;

    rqu_abs #(.DOT_W(DOT_W)) u_abs (
        .dot_i       (dot_i),
        .twice_mag_o (twice_mag_w),
        .neg_o       (neg_w)
    );

    rqu_thresh #(
        .NRM_W (NRM_W),
        .CMP_W (CMP_W),
        .N_THR (N_THR),
        .MUL_B (MUL_B)
    ) u_thresh (
        .nrm_i (nrm_i),
        .lhs_i (CMP_W'(twice_mag_w)),
        .ge_o  (ge_w)
    );

    rqu_select #(
        .N_THR (N_THR),
        .MAG_W (MAG_W)
    ) u_select (
        .ge_i  (ge_w),
        .mag_o (mag_w),
        .ovf_o (ovf_w)
    );

    always_comb begin
        magq_w    = {1'b0, mag_w};
        res_d     = '0;
        res_d.ovf = ovf_w;
        res_d.red = !ovf_w && (mag_w != '0);
        if (ovf_w) begin
            res_d.q = '0;
        end else if (neg_w) begin
            res_d.q = -magq_w;
        end else begin
            res_d.q = magq_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign q_o      = res_q.q;
    assign reduce_o = res_q.red;
    assign ovf_o    = res_q.ovf;

    // Marks cycles whose outputs come from sampled operands rather than reset
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R6
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (q_o == '0 && !reduce_o));

    // R7
    reduce_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduce_o == (q_o != '0));

    // R5
    sign_pos_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (q_o > 0) |-> !$past(dot_i[DOT_W-1]));

    // R5
    sign_neg_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (q_o < 0) |-> $past(dot_i[DOT_W-1]));

    // R8
    zero_norm_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(nrm_i) == '0) |-> ovf_o);

    // R4
    thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ge_w >> 1) & ~ge_w) == '0);

    // R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o <= $signed(Q_W'(QMAX))) && (q_o >= -$signed(Q_W'(QMAX))));
endmodule

// File: tb/rquot_unit_tb.sv
`timescale 1ns/1ps
module rquot_unit_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [31:0] dot = 32'sd100;
    logic [31:0]        nrm = 32'd10;
    logic signed [3:0]  q_o;
    logic               reduce_o;
    logic               ovf_o;

    int    checks = 0;
    int    errors = 0;
    int    exp_q = 0;
    bit    exp_red = 1'b0;
    bit    exp_ovf = 1'b0;
    bit    have_exp = 1'b0;
    string exp_tag = "";

    always #10 clk = ~clk;

    rquot_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot_i    (dot),
        .nrm_i    (nrm),
        .q_o      (q_o),
        .reduce_o (reduce_o),
        .ovf_o    (ovf_o)
    );

    // Behavioural reference: exact rounding by integer arithmetic
    task automatic refm(input longint d, input longint n,
                        output int q, output bit red, output bit ovf);
        longint a2;
        longint mag;
        a2 = 2 * ((d < 0) ? -d : d);
        if (a2 >= 9 * n) begin
            ovf = 1'b1;
            q   = 0;
        end else begin
            ovf = 1'b0;
            mag = (a2 + n) / (2 * n);
            q   = (d < 0) ? -int'(mag) : int'(mag);
        end
        red = (q != 0);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        if (have_exp) begin
            cmp({exp_tag, "/R2"}, "q_o", int'(q_o), exp_q);
            cmp("R7", "reduce_o", int'(reduce_o), int'(exp_red));
            cmp(exp_tag, "ovf_o", int'(ovf_o), int'(exp_ovf));
        end
    endtask

    task automatic load(input longint d, input longint n, input string tag);
        dot = d[31:0];
        nrm = n[31:0];
        refm(longint'(dot), longint'(nrm), exp_q, exp_red, exp_ovf);
        if (tag == "") begin
            if (exp_ovf)         exp_tag = (nrm == 0) ? "R8" : "R6";
            else if (exp_q == 0) exp_tag = "R3";
            else                 exp_tag = (exp_q < 0) ? "R4/R5" : "R4";
        end else begin
            exp_tag = tag;
        end
        have_exp = 1'b1;
    endtask

    task automatic apply(input longint d, input longint n, input string tag);
        @(negedge clk);
        check_now();
        load(d, n, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs held at zero during reset despite live operands
        repeat (3) begin
            @(negedge clk);
            cmp("R1", "q_o", int'(q_o), 0);
            cmp("R1", "reduce_o", int'(reduce_o), 0);
            cmp("R1", "ovf_o", int'(ovf_o), 0);
        end
        rst_n = 1'b1;
        load(4, 10, "R3");

        // Boundaries with n = 10: thresholds on 2|dot| at 10, 30, 50, 70, 90
        apply(5, 10, "R4");
        apply(14, 10, "R4");
        apply(15, 10, "R4");
        apply(24, 10, "R4");
        apply(25, 10, "R4");
        apply(34, 10, "R4");
        apply(35, 10, "R4");
        apply(44, 10, "R4");
        apply(45, 10, "R6");
        apply(0, 10, "R3");
        apply(-4, 10, "R5");
        apply(-5, 10, "R5");
        apply(-15, 10, "R5");
        apply(-35, 10, "R5");
        apply(-44, 10, "R5");
        apply(-45, 10, "R6");
        // Odd norm
        apply(3, 7, "R3");
        apply(4, 7, "R4");
        apply(10, 7, "R4");
        apply(11, 7, "R4");
        // Zero norm
        apply(0, 0, "R8");
        apply(-3, 0, "R8");
        apply(12345, 0, "R8");
        // Extremes
        apply(-64'sd2147483648, 64'd4294967295, "R9");
        apply(64'sd2147483647, 64'd4294967295, "R9");
        apply(-64'sd2147483648, 1, "R9");
        apply(64'sd2147483647, 64'd477218588, "R9");
        apply(64'sd2147483647, 64'd477218589, "R9");
        apply(-64'sd2147483647, 64'd477218589, "R9");

        // Mixed operands around the supported range
        for (int i = 0; i < 3000; i++) begin
            longint n;
            longint d;
            n = (i % 97 == 0) ? 0 : longint'($urandom_range(1, 5000));
            d = longint'($urandom_range(0, 10 * 5000)) % (5 * n + 3);
            if ($urandom_range(0, 1) == 1) d = -d;
            apply(d, n, "");
        end

        @(negedge clk);
        check_now();
        have_exp = 1'b0;

        // R1: asynchronous clear mid-run, before any clock edge
        load(35, 10, "R4");
        have_exp = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        cmp("R1", "q_o", int'(q_o), 0);
        cmp("R1", "reduce_o", int'(reduce_o), 0);
        cmp("R1", "ovf_o", int'(ovf_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule